// File: doc/BRIEF.md
# Serial Audio Transmit Framer with Orderly Shutdown

This block is the transmit side of a serial audio port that acts as clock and frame-sync master. It divides the system clock down to a bit clock and sends one frame sync pulse at the start of every frame. Each frame carries one parallel word, shifted out most significant bit first. Words arrive through a valid/ready handshake, one word per data frame.

Clearing the transmit enable never cuts a frame short. Four bit periods before each frame ends, the block takes a snapshot of the enable, and that snapshot decides whether another frame follows. A separate clock-stop control then decides what happens at the boundary. If it was seen during the finishing frame or the frame before it, the bit clock and frame sync stop and a sticky done flag is raised. Otherwise the clocks keep running, carrying empty frames, until a stop request arrives. Software polls the done flag to learn that the port is quiet. It clears the flag by pulsing a clear input or by enabling the port again.

Top module: `sfx_frame_tx`

## Requirements
- R1: When `tx_en` is low at the commit point, the frame in progress still sends all `frame_len` bits. The commit point is the falling bit-clock edge that starts bit index `frame_len-4`, with bits numbered from 0. If a stop is in force, no further frame sync follows that frame.
- R2: When `tx_en` is high at the commit point and goes low before the frame ends, exactly one extra frame is sent. That frame has full length, `ser_dat` stays low for all of it, and no word is taken for it.
- R3: The stop is in force at a frame boundary when `clk_stop_req` is high at that boundary, or was high in any cycle of the finishing frame or of the frame before it. A request seen only two frames earlier does not stop the clocks.
- R4: When the enable has been cleared and no stop is in force, `ser_clk` and `ser_fs` keep running. The frames carry a low `ser_dat` and `frame_done` stays low. Raising `clk_stop_req` later stops the clocks at the end of the frame in progress.
- R5: `frame_done` rises in the cycle after the clocks stop. It then stays high until `done_clr` is pulsed or transmission is enabled again, and it is low after reset.
- R6: While running, `ser_clk` has a period of 2*(`half_div`+1) system cycles, with `half_div`+1 of them high. Once stopped, and after reset, `ser_clk`, `ser_fs` and `ser_dat` are held low.
- R7: `ser_fs` is high for exactly one bit period, covering bit 0 of every frame. Every frame is `frame_len` bits long, with a minimum of 8.
- R8: Each data frame starts with a one-cycle `tx_ready` pulse, and the word on `tx_data` is taken if `tx_valid` is high in that cycle. The word is sent most significant bit first. Bits change on the falling edge of `ser_clk`. If the frame is longer than the word, the extra bits are zeros; if it is shorter, the low bits of the word are dropped.
- R9: If `tx_valid` is low at a data frame start, the frame is sent as all zeros and `underrun` is high for one cycle, the cycle after `tx_ready`.
- R10: Setting `tx_en` again while the clocks are running empty frames restarts transmission. The first frame whose commit point sees the enable high is followed by a data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| clk_stop_req | input | 1 | Request to stop bit clock and frame sync once transmission ends |
| frame_len | input | LEN_W | Bits per frame (8 or more) |
| half_div | input | DIV_W | Bit-clock half period minus one, in system cycles |
| tx_data | input | DATA_W | Word for the next data frame |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | A data frame is starting and takes the word now |
| done_clr | input | 1 | Write-one-to-clear for `frame_done` |
| frame_done | output | 1 | Sticky flag: clocks have stopped after shutdown |
| underrun | output | 1 | One-cycle pulse: a data frame started with no word |
| ser_clk | output | 1 | Bit clock |
| ser_fs | output | 1 | Frame sync |
| ser_dat | output | 1 | Serial data |

## Verification
`tx_ready` is combinational and falls in the same cycle as the decision to start a frame. `underrun` follows one cycle later, together with the first cycle of `ser_fs` high. `frame_done` rises one cycle after the last falling bit-clock edge. Serial bits are valid at every rising edge of `ser_clk`. The bench drives its inputs just after a falling system-clock edge and decodes the serial lines at each rising bit-clock edge. It waits on observed frame-sync starts and bit counts rather than on fixed cycle offsets, so each check lands in the bit or cycle where its result is defined.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    // Number of whole bit periods between the enable snapshot and the frame end.
    localparam int COMMIT_LEAD = 4;

    // Shortest frame that leaves room for the snapshot after bit 0.
    localparam int MIN_FRAME = 8;

    typedef enum logic {
        LNK_OFF = 1'b0,
        LNK_RUN = 1'b1
    } link_state_e;

    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_DATA  = 2'd1,
        FR_BLANK = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic start;   // leave the stopped state
        logic load;    // a data frame begins, take a word
        logic halt;    // stop clocks at this boundary
    } frame_evt_t;

    // Bit index whose closing falling edge is the enable snapshot point.
    function automatic int commit_index(input int len);
        return len - COMMIT_LEAD - 1;
    endfunction

endpackage

// File: rtl/sfx_bitclk.sv
module sfx_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             bit_fall
);

    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;
    logic             wrap;

    assign wrap     = run && (cnt_q >= half_div);
    assign bit_fall = wrap && sck_q;
    assign sck      = sck_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R6: the level holds until the half period has elapsed
    a_r6_even_phase: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q < half_div) |=> (sck_q == $past(sck_q)));

endmodule

// File: rtl/sfx_framer.sv
module sfx_framer
    import sfx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             stop_req,
    input  logic             done_clr,
    input  logic             bit_fall,
    input  logic             sck_in,
    input  logic [LEN_W-1:0] frame_len,
    output logic             running,
    output logic             fs,
    output logic             data_frame,
    output logic             load,
    output logic             done
);

    link_state_e      state_q;
    frame_kind_e      kind_q;
    logic [LEN_W-1:0] pos_q;
    logic             commit_q;
    logic             stop_cur_q;
    logic             stop_prev_q;
    logic             en_q;
    logic             done_q;

    logic             last_bit;
    logic             at_commit;
    logic             frame_end;
    logic             stop_any;
    logic             halt_w;
    frame_evt_t       evt;

    always_comb begin
        last_bit  = pos_q >= (frame_len - LEN_W'(1));
        at_commit = bit_fall && (pos_q == LEN_W'(commit_index(int'(frame_len))));
        frame_end = (state_q == LNK_RUN) && bit_fall && last_bit;
        stop_any  = stop_cur_q || stop_prev_q || stop_req;
        evt.start = (state_q == LNK_OFF) && tx_en;
        evt.load  = evt.start || (frame_end && commit_q && tx_en);
        evt.halt  = frame_end && !commit_q && stop_any;
        halt_w    = evt.halt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= LNK_OFF;
            kind_q      <= FR_NONE;
            pos_q       <= '0;
            commit_q    <= 1'b0;
            stop_cur_q  <= 1'b0;
            stop_prev_q <= 1'b0;
            en_q        <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (evt.start) begin
                state_q     <= LNK_RUN;
                kind_q      <= FR_DATA;
                pos_q       <= '0;
                commit_q    <= 1'b0;
                stop_cur_q  <= stop_req;
                stop_prev_q <= 1'b0;
            end else if (state_q == LNK_RUN && bit_fall) begin
                if (last_bit) begin
                    pos_q       <= '0;
                    commit_q    <= 1'b0;
                    stop_prev_q <= stop_cur_q;
                    stop_cur_q  <= stop_req;
                    if (evt.halt) begin
                        state_q <= LNK_OFF;
                        kind_q  <= FR_NONE;
                    end else begin
                        kind_q  <= evt.load ? FR_DATA : FR_BLANK;
                    end
                end else begin
                    pos_q      <= pos_q + LEN_W'(1);
                    stop_cur_q <= stop_cur_q || stop_req;
                    if (at_commit) begin
                        commit_q <= tx_en;
                    end
                end
            end else if (state_q == LNK_RUN) begin
                stop_cur_q <= stop_cur_q || stop_req;
            end

            if (evt.halt) begin
                done_q <= 1'b1;
            end else if (done_clr || (tx_en && !en_q) || evt.start) begin
                done_q <= 1'b0;
            end
        end
    end

    assign running    = (state_q == LNK_RUN);
    assign fs         = running && (pos_q == '0);
    assign data_frame = (kind_q == FR_DATA);
    assign load       = evt.load;
    assign done       = done_q;

    // R1: the link only leaves the running state on a frame boundary
    a_r1_halt_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (state_q == LNK_RUN && !frame_end) |=> (state_q == LNK_RUN));

    // R2: a late enable clear yields one blank frame
    a_r2_extra_blank: assert property (@(posedge clk) disable iff (rst)
        (frame_end && commit_q && !tx_en) |=> (state_q == LNK_RUN && kind_q == FR_BLANK));

    // R3: a stop seen in the previous frame is honoured
    a_r3_prev_frame_stop: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !commit_q && stop_prev_q) |=> (state_q == LNK_OFF));

    // R4: without a stop the clocks roll into a new frame
    a_r4_keep_rolling: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !commit_q && !stop_any) |=> (state_q == LNK_RUN && fs));

    // R5: stopping raises the done flag
    a_r5_done_after_halt: assert property (@(posedge clk) disable iff (rst)
        halt_w |=> done_q);

    // R6: a parked link keeps the bit clock low
    a_r6_clock_parked: assert property (@(posedge clk) disable iff (rst)
        (state_q == LNK_OFF && $past(state_q) == LNK_OFF) |-> !sck_in);

endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    input  logic              din_valid,
    input  logic              data_frame,
    output logic              sd,
    output logic              underrun
);

    logic [DATA_W-1:0] sh_q;
    logic              under_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            under_q <= 1'b0;
        end else begin
            under_q <= load && !din_valid;
            if (load) begin
                sh_q <= din_valid ? din : '0;
            end else if (shift) begin
                sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign sd       = data_frame && sh_q[DATA_W-1];
    assign underrun = under_q;

    // R9: a missing word turns into an all-zero frame and a flag
    a_r9_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (load && !din_valid) |=> (sh_q == '0 && under_q));

    // R8: an offered word is captured whole at the frame start
    a_r8_word_capture: assert property (@(posedge clk) disable iff (rst)
        (load && din_valid) |=> (sh_q == $past(din)));

endmodule

// File: rtl/sfx_frame_tx.sv
module sfx_frame_tx
    import sfx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              clk_stop_req,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              done_clr,
    output logic              frame_done,
    output logic              underrun,
    output logic              ser_clk,
    output logic              ser_fs,
    output logic              ser_dat
);

    logic running;
    logic bit_fall;
    logic data_frame;
    logic load;

    sfx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .half_div (half_div),
        .sck      (ser_clk),
        .bit_fall (bit_fall)
    );

    sfx_framer #(.LEN_W(LEN_W)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .stop_req   (clk_stop_req),
        .done_clr   (done_clr),
        .bit_fall   (bit_fall),
        .sck_in     (ser_clk),
        .frame_len  (frame_len),
        .running    (running),
        .fs         (ser_fs),
        .data_frame (data_frame),
        .load       (load),
        .done       (frame_done)
    );

    sfx_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .shift      (bit_fall),
        .din        (tx_data),
        .din_valid  (tx_valid),
        .data_frame (data_frame),
        .sd         (ser_dat),
        .underrun   (underrun)
    );

    assign tx_ready = load;

    // R7: frame sync never shows while the link is parked
    a_r7_fs_only_running: assert property (@(posedge clk) disable iff (rst)
        ser_fs |-> ser_clk || !$past(ser_fs) || running);

endmodule

// File: tb/sfx_frame_tx_tb.sv
module sfx_frame_tx_tb;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 8;
    localparam int DIV_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              tx_en = 1'b0;
    logic              stop_req = 1'b0;
    logic              done_clr = 1'b0;
    logic              tx_valid = 1'b0;
    logic [LEN_W-1:0]  frame_len = 8'd16;
    logic [DIV_W-1:0]  half_div = 8'd1;
    logic [DATA_W-1:0] tx_data;
    logic              tx_ready, frame_done, underrun, ser_clk, ser_fs, ser_dat;

    int n_tests = 0;
    int n_fail  = 0;

    function automatic logic [31:0] word_fn(input int unsigned k);
        return ((k + 1) * 32'h9E3779B1) ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [63:0] exp_bits(input logic [31:0] w, input int len);
        logic [63:0] x = {32'b0, w};
        if (len <= 32) return x >> (32 - len);
        return x << (len - 32);
    endfunction

    int unsigned acc_idx = 0;
    assign tx_data = word_fn(acc_idx);
    always @(posedge clk) if (!rst && tx_ready && tx_valid) acc_idx <= acc_idx + 1;

    sfx_frame_tx #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .clk_stop_req(stop_req),
        .frame_len(frame_len), .half_div(half_div), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .done_clr(done_clr),
        .frame_done(frame_done), .underrun(underrun), .ser_clk(ser_clk),
        .ser_fs(ser_fs), .ser_dat(ser_dat)
    );

    // Monitor: decodes the serial lines on the falling system-clock edge
    int          cyc = 0, rises = 0, frames_seen = 0, last_rise = -1, rise_per = 0;
    int          fs_hi = 0, fs_width = 0, sck_hi = 0, sck_hi_w = 0, un_cnt = 0;
    logic        sck_prev = 1'b0, fs_prev = 1'b0, started = 1'b0;
    logic [63:0] cur_bits = '0;
    int          cur_len = 0, fr_cnt = 0;
    logic [63:0] fr_bits [0:511];
    int          fr_len  [0:511];

    always @(negedge clk) begin
        cyc++;
        if (underrun) un_cnt++;
        if (ser_fs && !fs_prev) fs_hi = 1; else if (ser_fs) fs_hi++;
        if (!ser_fs && fs_prev) fs_width = fs_hi;
        if (ser_clk && !sck_prev) sck_hi = 1; else if (ser_clk) sck_hi++;
        if (!ser_clk && sck_prev) sck_hi_w = sck_hi;
        if (ser_clk && !sck_prev) begin
            rises++;
            if (last_rise >= 0) rise_per = cyc - last_rise;
            last_rise = cyc;
            if (ser_fs) begin
                if (started) begin
                    fr_bits[fr_cnt % 512] = cur_bits;
                    fr_len[fr_cnt % 512]  = cur_len;
                    fr_cnt++;
                end
                started = 1'b1;
                frames_seen++;
                cur_bits = {63'b0, ser_dat};
                cur_len  = 1;
            end else begin
                cur_bits = {cur_bits[62:0], ser_dat};
                cur_len++;
            end
        end
        sck_prev = ser_clk;
        fs_prev  = ser_fs;
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wait_frames(input int target);
        int g = 0;
        while (frames_seen < target && g < 6000) begin tick(1); g++; end
    endtask

    task automatic wait_bits(input int b);
        int g = 0;
        while (cur_len != b && g < 6000) begin tick(1); g++; end
    endtask

    task automatic wait_done();
        int g = 0;
        while (!frame_done && g < 6000) begin tick(1); g++; end
    endtask

    // One enable/shutdown cycle with a stop in force: three frames, optional late clear
    task automatic session(input int hp, input int len, input bit valid, input bit late);
        int unsigned a;
        int f0, u, b, r;
        half_div = DIV_W'(hp);
        frame_len = LEN_W'(len);
        stop_req = 1'b1;
        tx_valid = valid;
        a = acc_idx; u = un_cnt; f0 = frames_seen;
        tx_en = 1'b1;
        wait_frames(f0 + 1);
        b = fr_cnt;
        wait_frames(f0 + 2);
        chk("R6", "bit clock period", 64'(rise_per), 64'(2 * (hp + 1)));
        chk("R6", "bit clock high time", 64'(sck_hi_w), 64'(hp + 1));
        chk("R7", "frame sync width", 64'(fs_width), 64'(2 * (hp + 1)));
        wait_frames(f0 + 3);
        wait_bits(late ? len - 1 : 1);
        tx_en = 1'b0;
        wait_done();
        tick(2);
        chk(late ? "R2" : "R1", "frames sent", 64'(frames_seen - f0), 64'(late ? 4 : 3));
        chk("R8", "words taken", 64'(acc_idx - a), 64'(valid ? 3 : 0));
        chk("R9", "underrun pulses", 64'(un_cnt - u), 64'(valid ? 0 : 3));
        for (int k = 0; k < 2; k++) begin
            chk("R7", "frame length", 64'(fr_len[(b + k) % 512]), 64'(len));
            chk(valid ? "R8" : "R9", "frame bits", fr_bits[(b + k) % 512],
                valid ? exp_bits(word_fn(a + k), len) : 64'b0);
        end
        if (late) begin
            chk("R8", "third frame bits", fr_bits[(b + 2) % 512],
                valid ? exp_bits(word_fn(a + 2), len) : 64'b0);
            chk("R2", "extra frame bits", cur_bits, 64'b0);
        end else begin
            chk("R1", "last frame bits", cur_bits, valid ? exp_bits(word_fn(a + 2), len) : 64'b0);
        end
        chk("R1", "last frame completed", 64'(cur_len), 64'(len));
        chk("R5", "done after stop", 64'(frame_done), 64'd1);
        r = rises;
        tick(24);
        chk("R6", "clock parked", 64'({ser_clk, ser_fs, ser_dat}), 64'd0);
        chk("R6", "no edges when parked", 64'(rises), 64'(r));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned a, seed;
        int f0, b;
        seed = $urandom(32'd7321);
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R6", "reset outputs", 64'({ser_clk, ser_fs, ser_dat, tx_ready, underrun}), 64'd0);
        chk("R5", "reset done flag", 64'(frame_done), 64'd0);

        // Directed shutdown cases
        session(1, 16, 1'b1, 1'b0);
        session(1, 16, 1'b1, 1'b1);
        session(0, 8, 1'b0, 1'b0);
        session(2, 40, 1'b1, 1'b0);

        // R5: write-one-to-clear
        done_clr = 1'b1; tick(1); done_clr = 1'b0;
        chk("R5", "clear pulse", 64'(frame_done), 64'd0);
        session(0, 10, 1'b1, 1'b0);

        // R4: no stop, clocks keep running, then a late stop
        half_div = 8'd1; frame_len = 8'd12; stop_req = 1'b0; tx_valid = 1'b1;
        a = acc_idx; f0 = frames_seen;
        tx_en = 1'b1;
        tick(1);
        chk("R5", "enable clears done", 64'(frame_done), 64'd0);
        wait_frames(f0 + 1);
        b = fr_cnt;
        wait_frames(f0 + 2);
        tx_en = 1'b0;
        wait_frames(f0 + 5);
        chk("R4", "still framing", 64'(frames_seen - f0), 64'd5);
        chk("R4", "done stays low", 64'(frame_done), 64'd0);
        chk("R4", "last data frame", fr_bits[(b + 1) % 512], exp_bits(word_fn(a + 1), 12));
        chk("R4", "idle frame low", fr_bits[(b + 2) % 512], 64'b0);
        chk("R4", "idle frame length", 64'(fr_len[(b + 3) % 512]), 64'd12);
        chk("R8", "no word in idle", 64'(acc_idx - a), 64'd2);
        stop_req = 1'b1;
        wait_done();
        tick(2);
        chk("R4", "stop ends frame", 64'(frames_seen - f0), 64'd5);
        chk("R4", "stopped frame whole", 64'(cur_len), 64'd12);
        chk("R4", "done after late stop", 64'(frame_done), 64'd1);

        // R3: stop pulse in the previous frame is honoured
        stop_req = 1'b0; f0 = frames_seen;
        tx_en = 1'b1;
        wait_frames(f0 + 2);
        wait_bits(3);
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        wait_frames(f0 + 3);
        tx_en = 1'b0;
        wait_done();
        tick(2);
        chk("R3", "previous-frame stop", 64'(frames_seen - f0), 64'd3);
        chk("R3", "done set", 64'(frame_done), 64'd1);

        // R3: a pulse two frames back does not stop
        f0 = frames_seen;
        tx_en = 1'b1;
        wait_frames(f0 + 1);
        wait_bits(3);
        stop_req = 1'b1; tick(1); stop_req = 1'b0;
        wait_frames(f0 + 3);
        tx_en = 1'b0;
        wait_frames(f0 + 4);
        chk("R3", "old stop ignored", 64'(frames_seen - f0), 64'd4);
        chk("R3", "done low while running", 64'(frame_done), 64'd0);
        stop_req = 1'b1;
        wait_done();
        tick(2);

        // R10: restart while empty frames roll
        stop_req = 1'b0; a = acc_idx; f0 = frames_seen;
        tx_en = 1'b1;
        wait_frames(f0 + 1);
        b = fr_cnt;
        wait_frames(f0 + 2);
        tx_en = 1'b0;
        wait_frames(f0 + 4);
        tx_en = 1'b1;
        wait_frames(f0 + 6);
        chk("R10", "idle before restart", fr_bits[(b + 3) % 512], 64'b0);
        chk("R10", "restart data frame", fr_bits[(b + 4) % 512], exp_bits(word_fn(a + 2), 12));
        stop_req = 1'b1;
        tx_en = 1'b0;
        wait_done();
        tick(2);
        chk("R10", "frames in restart run", 64'(frames_seen - f0), 64'd6);
        chk("R10", "final word", cur_bits, exp_bits(word_fn(a + 3), 12));

        // Random sessions
        for (int i = 0; i < 8; i++) begin
            int hp = int'($urandom % 4);
            int ln = 8 + int'($urandom % 33);
            bit vl = ($urandom % 4) != 0;
            bit lt = ($urandom % 2) != 0;
            session(hp, ln, vl, lt);
        end

        finish_run();
    end

endmodule